// File: doc/BRIEF.md
# Bit-Field Insert and Extract Unit

This block is a 64-bit execution slice for field manipulation. Each request on the input strobe selects one of eight operations: field insert, field extract, byte-granular funnel pick from a pair of registers, and the two conditional zeroing operations. Each of the first three comes in a 32-bit word flavour and a 64-bit doubleword flavour. The result and an illegal-operation flag are captured one clock after the strobe and are marked by an output-valid signal.

The control is a two-state machine. `ST_IDLE` means no fresh result is being presented. `ST_LOADED` means the result register was written on the last edge. The transition `T_ACCEPT` moves to `ST_LOADED` whenever `in_valid` is high, from either state. The transition `T_DRAIN` moves back to `ST_IDLE` when `in_valid` is low. A field operation whose low bound is above its high bound reports the illegal flag and a zero result. The flag stays low for all other operations.

Top module: `bfu_top`

## Requirements
- R1: Doubleword insert (op 3'd1) returns `dst_old` with bits [ms:ls] replaced by the low ms-ls+1 bits of `src_b`, using 6-bit ms/ls.
- R2: Doubleword extract (op 3'd3) returns `src_a` bits [ms:ls] shifted down to bit 0, with every bit above the field cleared.
- R3: For an insert or extract (ops 0..3) whose ls is greater than its ms, `illegal` is 1 and `result` is zero.
- R4: Word insert (op 3'd0) and word extract (op 3'd2) use only bits [4:0] of ms and ls and work on the low 32 bits of the operands. Their 32-bit result is sign-extended from bit 31 into bits [63:32].
- R5: Word pick (op 3'd4) forms {src_b[31:0], src_a[31:0]}. It takes 32 bits starting at bit 32-8*sa, using sa[1:0], and sign-extends them to 64 bits.
- R6: Doubleword pick (op 3'd5) takes 64 bits from the 128-bit value {src_b, src_a}, starting at bit 64-8*sa, using sa[2:0].
- R7: Zero-if-zero (op 3'd6) returns 0 when `src_b` is zero and returns `src_a` otherwise.
- R8: Zero-if-nonzero (op 3'd7) returns 0 when `src_b` is nonzero and returns `src_a` otherwise.
- R9: `illegal` is 0 for ops 4..7, whatever ms and ls hold.
- R10: A request presented with `in_valid` high appears on `result`, `illegal` and `out_valid` after exactly one rising edge. In a cycle after `in_valid` was low, `out_valid` is 0 and `result` keeps its previous value.
- R11: While `rst_n` is low, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation select |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| dst_old | input | 64 | Current destination value for insert |
| ms | input | 6 | High field bound |
| ls | input | 6 | Low field bound |
| sa | input | 3 | Byte-pick shift in bytes |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 64 | Operation result |
| illegal | output | 1 | Field bounds were invalid |

## Verification
The bench builds the unit with its default width of 64, so the word path is instantiated at 32 bits and the doubleword path at 64. This puts the extreme bounds in reach on both paths: ms at 31 and 63, ls at 0, and ms equal to ls. It also reaches every byte-pick shift, including the zero shift on both widths, where the whole second operand is returned. Word cases set bit 5 of ms and ls and fill the upper halves of the operands with data, to show that those bits are ignored and that the sign extension is applied.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic [2:0] {
        OP_INS_W      = 3'd0,
        OP_INS_D      = 3'd1,
        OP_EXT_W      = 3'd2,
        OP_EXT_D      = 3'd3,
        OP_PICK_W     = 3'd4,
        OP_PICK_D     = 3'd5,
        OP_ZERO_IF_Z  = 3'd6,
        OP_ZERO_IF_NZ = 3'd7
    } bfu_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } bfu_state_e;

endpackage

// File: rtl/bfu_field.sv
// Bounded field insert / extract over a W-bit operand.
module bfu_field #(
    parameter int W  = 64,
    parameter int BW = $clog2(W)
) (
    input  logic          do_insert,
    input  logic [W-1:0]  src,
    input  logic [W-1:0]  ins,
    input  logic [W-1:0]  dst,
    input  logic [BW-1:0] hi,
    input  logic [BW-1:0] lo,
    output logic [W-1:0]  res,
    output logic          bad
);
    localparam logic [BW-1:0] TOP = BW'(W - 1);

    logic [W-1:0] upto_hi;
    logic [W-1:0] from_lo;
    logic [W-1:0] fmask;
    logic [W-1:0] ins_res;
    logic [W-1:0] ext_res;

    always_comb begin
        upto_hi = {W{1'b1}} >> (TOP - hi);
        from_lo = {W{1'b1}} << lo;
        fmask   = upto_hi & from_lo;
        ins_res = (dst & ~fmask) | ((ins << lo) & fmask);
        ext_res = (src & upto_hi) >> lo;
        bad     = (lo > hi);
        if (bad)
            res = '0;
        else if (do_insert)
            res = ins_res;
        else
            res = ext_res;
    end
endmodule

// File: rtl/bfu_pick.sv
// Byte-granular funnel pick, word and doubleword flavours.
module bfu_pick #(
    parameter int XLEN = 64,
    parameter int HALF = XLEN / 2,
    parameter int SAW  = $clog2(XLEN / 8)
) (
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [SAW-1:0]  sa,
    output logic [XLEN-1:0] pick_w,
    output logic [XLEN-1:0] pick_d
);
    localparam int SHW = $clog2(2 * XLEN) + 1;

    logic [XLEN-1:0]   cat_w;
    logic [2*XLEN-1:0] cat_d;
    logic [XLEN-1:0]   sh_w;
    logic [2*XLEN-1:0] sh_d;
    logic [SHW-1:0]    amt_w;
    logic [SHW-1:0]    amt_d;

    always_comb begin
        cat_w  = {src_b[HALF-1:0], src_a[HALF-1:0]};
        cat_d  = {src_b, src_a};
        amt_w  = SHW'(HALF) - SHW'({sa[SAW-2:0], 3'b000});
        amt_d  = SHW'(XLEN) - SHW'({sa, 3'b000});
        sh_w   = cat_w >> amt_w;
        sh_d   = cat_d >> amt_d;
        pick_w = {{HALF{sh_w[HALF-1]}}, sh_w[HALF-1:0]};
        pick_d = sh_d[XLEN-1:0];
    end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
    import bfu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int FW   = $clog2(XLEN),
    parameter int SAW  = $clog2(XLEN / 8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] dst_old,
    input  logic [FW-1:0]   ms,
    input  logic [FW-1:0]   ls,
    input  logic [SAW-1:0]  sa,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            illegal
);
    localparam int HALF = XLEN / 2;
    localparam int HFW  = FW - 1;

    bfu_op_e    op_e;
    bfu_state_e state_q, state_d;

    logic [HALF-1:0] w_res;
    logic            w_bad;
    logic [XLEN-1:0] d_res;
    logic            d_bad;
    logic [XLEN-1:0] pick_w, pick_d;
    logic [XLEN-1:0] res_d;
    logic            bad_d;

    assign op_e = bfu_op_e'(op);

    // Word and doubleword field paths share one parameterised datapath.
    for (genvar g = 0; g < 2; g++) begin : g_field
        if (g == 0) begin : g_word
            bfu_field #(.W(HALF)) u_field (
                .do_insert (op_e == OP_INS_W),
                .src       (src_a[HALF-1:0]),
                .ins       (src_b[HALF-1:0]),
                .dst       (dst_old[HALF-1:0]),
                .hi        (ms[HFW-1:0]),
                .lo        (ls[HFW-1:0]),
                .res       (w_res),
                .bad       (w_bad)
            );
        end else begin : g_dword
            bfu_field #(.W(XLEN)) u_field (
                .do_insert (op_e == OP_INS_D),
                .src       (src_a),
                .ins       (src_b),
                .dst       (dst_old),
                .hi        (ms),
                .lo        (ls),
                .res       (d_res),
                .bad       (d_bad)
            );
        end
    end

    bfu_pick #(.XLEN(XLEN)) u_pick (
        .src_a  (src_a),
        .src_b  (src_b),
        .sa     (sa),
        .pick_w (pick_w),
        .pick_d (pick_d)
    );

    // Result selection
    always_comb begin
        res_d = '0;
        bad_d = 1'b0;
        unique case (op_e)
            OP_INS_W, OP_EXT_W: begin
                res_d = {{HALF{w_res[HALF-1]}}, w_res};
                bad_d = w_bad;
            end
            OP_INS_D, OP_EXT_D: begin
                res_d = d_res;
                bad_d = d_bad;
            end
            OP_PICK_W:     res_d = pick_w;
            OP_PICK_D:     res_d = pick_d;
            OP_ZERO_IF_Z:  res_d = (src_b == '0) ? '0 : src_a;
            OP_ZERO_IF_NZ: res_d = (src_b != '0) ? '0 : src_a;
            default: begin
                res_d = '0;
                bad_d = 1'b0;
            end
        endcase
    end

    // Next-state logic: T_ACCEPT / T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            result  <= res_d;
            illegal <= bad_d;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

    // R10
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal)));

    // R9
    nobound_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2]) |=> !illegal);

    // R3
    bad_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_e == OP_INS_D || op_e == OP_EXT_D) && (ls > ms))
        |=> (illegal && result == '0));

    // R4
    word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_e == OP_INS_W || op_e == OP_EXT_W || op_e == OP_PICK_W))
        |=> ($countones(result[XLEN-1:HALF-1]) == 0
             || $countones(result[XLEN-1:HALF-1]) == HALF + 1));

    // R7
    zero_if_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_ZERO_IF_Z && src_b == '0) |=> (result == '0));

    // R8
    zero_if_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_ZERO_IF_NZ && src_b != '0) |=> (result == '0));

endmodule

// File: tb/bfu_top_test.sv
`timescale 1ns/1ps
module bfu_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [63:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [5:0]  ms = '0, ls = '0;
    logic [2:0]  sa = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bfu_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .ms(ms), .ls(ls), .sa(sa),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] ref_ins(input bit word, input logic [63:0] d,
            input logic [63:0] b, input int m, input int l);
        logic [63:0] r = d;
        int w = word ? 32 : 64;
        if (l > m) return '0;
        for (int i = 0; i < w; i++)
            if (i >= l && i <= m) r[i] = b[i - l];
        return word ? sx32(r[31:0]) : r;
    endfunction

    function automatic logic [63:0] ref_ext(input bit word, input logic [63:0] a,
            input int m, input int l);
        logic [63:0] r = '0;
        if (l > m) return '0;
        for (int i = 0; i <= m - l; i++) r[i] = a[i + l];
        return word ? sx32(r[31:0]) : r;
    endfunction

    task automatic issue(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
            input logic [63:0] d, input logic [5:0] m, input logic [5:0] l, input logic [2:0] s);
        @(negedge clk);
        op = o; src_a = a; src_b = b; dst_old = d; ms = m; ls = l; sa = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R11 result", result, 64'd0);
        chk("R11 illegal", {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_insert_d;
        issue(3'd1, '0, 64'h0000_0000_0000_ABCD, 64'hFFFF_FFFF_FFFF_FFFF, 6'd23, 6'd8, 3'd0);
        chk("R1 ins mid", result, ref_ins(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hABCD, 23, 8));
        chk("R10 valid", {63'd0, out_valid}, 64'd1);
        issue(3'd1, '0, 64'h1234_5678_9ABC_DEF0, 64'h0, 6'd63, 6'd0, 3'd0);
        chk("R1 ins full", result, 64'h1234_5678_9ABC_DEF0);
        issue(3'd1, '0, 64'h1, 64'h0, 6'd63, 6'd63, 3'd0);
        chk("R1 ins top bit", result, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_extract_d;
        issue(3'd3, 64'hF0F0_1234_5678_0F0F, '0, '1, 6'd47, 6'd16, 3'd0);
        chk("R2 ext mid", result, 64'h0000_0000_1234_5678);
        issue(3'd3, 64'h8000_0000_0000_0000, '0, '0, 6'd63, 6'd63, 3'd0);
        chk("R2 ext top", result, 64'd1);
        issue(3'd3, 64'hDEAD_BEEF_CAFE_F00D, '0, '0, 6'd63, 6'd0, 3'd0);
        chk("R2 ext full", result, 64'hDEAD_BEEF_CAFE_F00D);
    endtask

    task automatic t_bounds;
        issue(3'd1, '1, '1, '1, 6'd4, 6'd5, 3'd0);
        chk("R3 ins_d illegal", {63'd0, illegal}, 64'd1);
        chk("R3 ins_d result", result, 64'd0);
        issue(3'd2, '1, '1, '1, 6'd3, 6'd30, 3'd0);
        chk("R3 ext_w illegal", {63'd0, illegal}, 64'd1);
        chk("R3 ext_w result", result, 64'd0);
        issue(3'd1, 64'h5, 64'h1, 64'h0, 6'd9, 6'd9, 3'd0);
        chk("R3 equal bounds legal", {63'd0, illegal}, 64'd0);
        chk("R3 equal bounds result", result, 64'h200);
    endtask

    task automatic t_word_field;
        // bit 5 of ms/ls set: must be ignored
        issue(3'd0, '0, 64'hFFFF_FFFF_0000_000F, 64'hAAAA_AAAA_0000_0000, 6'd35, 6'd32, 3'd0);
        chk("R4 ins_w low", result, ref_ins(1, 64'hAAAA_AAAA_0000_0000, 64'h0F, 3, 0));
        issue(3'd0, '0, 64'h1, 64'h0, 6'd31, 6'd31, 3'd0);
        chk("R4 ins_w sext", result, 64'hFFFF_FFFF_8000_0000);
        issue(3'd2, 64'h1234_5678_8000_0000, '0, '0, 6'd31, 6'd0, 3'd0);
        chk("R4 ext_w sext", result, 64'hFFFF_FFFF_8000_0000);
        issue(3'd2, 64'hFFFF_FFFF_ABCD_1234, '0, '0, 6'd47, 6'd40, 3'd0);
        chk("R4 ext_w field", result, ref_ext(1, 64'hABCD_1234, 15, 8));
    endtask

    task automatic t_pick_w;
        for (int s = 0; s < 4; s++) begin
            logic [63:0] cat = {32'h89AB_CDEF, 32'h0123_4567};
            logic [63:0] sh = cat >> (32 - 8 * s);
            issue(3'd4, 64'hFFFF_0000_0123_4567, 64'h5555_0000_89AB_CDEF, '0, '1, '1, 3'(s) | 3'b100);
            chk("R5 pick_w", result, sx32(sh[31:0]));
            chk("R9 pick_w legal", {63'd0, illegal}, 64'd0);
        end
    endtask

    task automatic t_pick_d;
        for (int s = 0; s < 8; s++) begin
            logic [127:0] cat = {64'hFEDC_BA98_7654_3210, 64'h0011_2233_4455_6677};
            logic [127:0] sh = cat >> (64 - 8 * s);
            issue(3'd5, 64'h0011_2233_4455_6677, 64'hFEDC_BA98_7654_3210, '0, 6'd0, 6'd63, 3'(s));
            chk("R6 pick_d", result, sh[63:0]);
        end
        chk("R9 pick_d legal", {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_mask;
        issue(3'd6, 64'hCAFE, 64'h0, '0, 6'd1, 6'd2, 3'd0);
        chk("R7 zero", result, 64'h0);
        chk("R9 mask legal", {63'd0, illegal}, 64'd0);
        issue(3'd6, 64'hCAFE, 64'h8000_0000_0000_0000, '0, 6'd0, 6'd0, 3'd0);
        chk("R7 pass", result, 64'hCAFE);
        issue(3'd7, 64'hBEEF, 64'h1, '0, 6'd0, 6'd0, 3'd0);
        chk("R8 zero", result, 64'h0);
        issue(3'd7, 64'hBEEF, 64'h0, '0, 6'd0, 6'd0, 3'd0);
        chk("R8 pass", result, 64'hBEEF);
    endtask

    task automatic t_hold;
        logic [63:0] prev = result;
        @(negedge clk);
        op = 3'd7; src_a = 64'h1111; src_b = 64'h0;
        @(negedge clk);
        chk("R10 out_valid low", {63'd0, out_valid}, 64'd0);
        chk("R10 result held", result, prev);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_insert_d();
        t_extract_d();
        t_bounds();
        t_word_field();
        t_pick_w();
        t_pick_d();
        t_mask();
        t_hold();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule